// File: doc/BRIEF.md
# Single-Wire Debug Link Bit Engine

This block is the target end of a half-duplex serial debug link that runs over one open-drain pin. The host starts every bit, in either direction, by pulling the pin low. The engine passes the pin through a synchronizer, detects the falling edge, and then times the whole bit window from the cycle in which it saw that edge. Each bit window lasts sixteen target clock cycles.

In receive mode the engine samples the pin level partway through the window and shifts the bits into a register, most significant bit first, as a byte or a word. In transmit mode it takes a byte or a word through a valid/ready handshake. For each bit the host starts, the engine then either holds the pin low for a 0 or, for a 1, drives the pin high for a single cycle to speed up the rise. If the host stops producing edges in the middle of a transfer, the engine drops the partial transfer, returns to idle and reports a timeout with a one-cycle flag.

Top module: `dbgpin_bit_engine`

## Requirements
- R1: While reset is asserted, and right after it, the pin is released (pinDriveEn=0, pinDriveVal=0), rxValid and timeout are low, and txReady is high.
- R2: pinIn passes through two synchronizer flops. A falling edge seen at the synchronizer output opens a bit window whose cycles are numbered 1 to 15 after the detection cycle. Any falling edge that arrives while a window is open is ignored.
- R3: In receive mode the synchronized level is sampled in window cycle 10, where low means 0 and high means 1. Bits enter most significant bit first. A receive started with rxIsWord=0 collects 8 bits into rxData[7:0] with rxData[15:8]=0. A receive started with rxIsWord=1 collects 16 bits.
- R4: After the window of the last receive bit closes, rxValid is high for exactly one cycle with the received value on rxData, and the engine goes back to idle.
- R5: txReady is high only when the engine is idle, no window is open and no edge is being detected in that cycle. A transfer is accepted on txValid and txReady. With txIsWord=0 only txData[7:0] is sent and txData[15:8] has no effect. With txIsWord=1 all 16 bits are sent, most significant bit first.
- R6: For a transmitted 0, the engine drives the pin low (pinDriveEn=1, pinDriveVal=0) in window cycles 1 to 12 and releases it from cycle 13.
- R7: For a transmitted 1, the engine drives the pin high (pinDriveEn=1, pinDriveVal=1) only in window cycle 4 and releases it in every other cycle.
- R8: The engine never drives the pin outside a transmit bit window, and pinDriveVal is never 1 while pinDriveEn is 0.
- R9: If a transfer is in progress (a transmit has been accepted, or a receive has started) and 512 cycles pass after the last accepted edge or load with no new edge, timeout pulses for one cycle. The partial transfer is discarded and the engine returns to idle, so the next edge starts a new receive.
- R10: Once the last transmit bit window closes, the engine returns to idle and txReady rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 1 | Level read back from the debug pin |
| pinDriveEn | output | 1 | Pin driver enable |
| pinDriveVal | output | 1 | Level driven when enabled |
| txValid | input | 1 | Transmit word offered |
| txReady | output | 1 | Engine can accept a transmit word |
| txData | input | 16 | Transmit value |
| txIsWord | input | 1 | 1: send 16 bits, 0: send low 8 bits |
| rxIsWord | input | 1 | Length of the next receive, latched at its first edge |
| rxValid | output | 1 | One-cycle strobe marking a completed receive |
| rxData | output | 16 | Received value |
| timeout | output | 1 | One-cycle strobe when a transfer is abandoned |

## Verification
The assertions assume that the host starts bits at least sixteen cycles apart and holds each pin level for longer than the two synchronizer stages. They also assume that txValid, txData and txIsWord stay stable until the handshake completes. The stimulus starts every bit on a 24-cycle grid and keeps a receive-0 low through cycle 13. It changes all inputs on the falling clock edge and holds txValid until txReady has been observed. Extra edges arrive only inside an already open window, and quiet gaps used to test the timeout are well past 512 cycles.

// File: rtl/dbgpin_pkg.sv
package dbgpin_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_RX   = 2'd1,
    MODE_TX   = 2'd2
  } linkMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture transmit value
    logic clear;    // wipe shift register
    logic sample;   // shift in synchronized pin level
    logic shift;    // advance transmit bit
    logic lowWin;   // window cycles where a 0 holds the pin low
    logic highWin;  // window cycle of the speedup pulse
    logic isWord;   // current transfer length select
  } dpStrobe_t;

endpackage

// File: rtl/dbgpin_datapath.sv
module dbgpin_datapath
  import dbgpin_pkg::*;
#(
  parameter int WORD_BITS   = 16,
  parameter int SHORT_BITS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pinIn,
  input  logic [WORD_BITS-1:0] txData,
  input  logic                 txIsWord,
  input  dpStrobe_t            strobe,
  output logic                 fall,
  output logic [WORD_BITS-1:0] rxData,
  output logic                 pinDriveEn,
  output logic                 pinDriveVal
);

  localparam int PAD_BITS = WORD_BITS - SHORT_BITS;

  logic [SYNC_STAGES:0]  syncReg;
  logic                  pinLevel;
  logic                  pinPrev;
  logic [WORD_BITS-1:0]  shiftReg;
  logic [WORD_BITS-1:0]  loadVal;
  logic                  curBit;

  // synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '1;
    else       syncReg <= {syncReg[SYNC_STAGES-1:0], pinIn};
  end

  assign pinLevel = syncReg[SYNC_STAGES-1];
  assign pinPrev  = syncReg[SYNC_STAGES];
  assign fall     = pinPrev & ~pinLevel;

  assign loadVal = txIsWord ? txData
                            : {txData[SHORT_BITS-1:0], {PAD_BITS{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.load) begin
      shiftReg <= loadVal;
    end else if (strobe.clear) begin
      shiftReg <= '0;
    end else if (strobe.sample) begin
      shiftReg <= {shiftReg[WORD_BITS-2:0], pinLevel};
    end else if (strobe.shift) begin
      shiftReg <= {shiftReg[WORD_BITS-2:0], 1'b0};
    end
  end

  assign curBit = shiftReg[WORD_BITS-1];

  assign rxData = strobe.isWord ? shiftReg
                                : {{PAD_BITS{1'b0}}, shiftReg[SHORT_BITS-1:0]};

  assign pinDriveEn  = (strobe.lowWin & ~curBit) | (strobe.highWin & curBit);
  assign pinDriveVal = strobe.highWin & curBit;

  // R7: the speedup pulse never lasts more than one cycle
  a_r7_speedup_single: assert property (@(posedge clk) disable iff (!rstN)
    (pinDriveEn && pinDriveVal) |=> !(pinDriveEn && pinDriveVal));

  // R6: a low drive never turns directly into a high drive
  a_r6_low_not_to_high: assert property (@(posedge clk) disable iff (!rstN)
    (pinDriveEn && !pinDriveVal) |=> !(pinDriveEn && pinDriveVal));

endmodule

// File: rtl/dbgpin_ctrl.sv
module dbgpin_ctrl
  import dbgpin_pkg::*;
#(
  parameter int WORD_BITS      = 16,
  parameter int SHORT_BITS     = 8,
  parameter int BIT_CYCLES     = 16,
  parameter int SAMPLE_AT      = 10,
  parameter int ZERO_END       = 13,
  parameter int SPEEDUP_AT     = 4,
  parameter int TIMEOUT_CYCLES = 512
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      fall,
  input  logic      txValid,
  input  logic      txIsWord,
  input  logic      rxIsWord,
  output logic      txReady,
  output logic      rxValid,
  output logic      timeout,
  output dpStrobe_t strobe
);

  localparam int PH_W  = $clog2(BIT_CYCLES);
  localparam int CNT_W = $clog2(WORD_BITS + 1);
  localparam int TO_W  = $clog2(TIMEOUT_CYCLES);

  linkMode_t        mode;
  logic             inBit;
  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] bitCnt;
  logic             isWord;
  logic [TO_W-1:0]  idleCnt;

  logic edgeAcc;
  logic txFire;
  logic bitEnd;
  logic lastBit;
  logic quietLimit;
  logic txWin;

  assign edgeAcc    = fall & ~inBit;
  assign txReady    = (mode == MODE_IDLE) & ~inBit & ~fall;
  assign txFire     = txValid & txReady;
  assign bitEnd     = inBit & (phase == PH_W'(BIT_CYCLES - 1));
  assign lastBit    = (bitCnt + CNT_W'(1)) ==
                      (isWord ? CNT_W'(WORD_BITS) : CNT_W'(SHORT_BITS));
  assign quietLimit = (mode != MODE_IDLE) & ~edgeAcc &
                      (idleCnt == TO_W'(TIMEOUT_CYCLES - 1));
  assign txWin      = inBit & (mode == MODE_TX);

  always_comb begin
    strobe         = '0;
    strobe.load    = txFire;
    strobe.clear   = (edgeAcc & (mode == MODE_IDLE)) | quietLimit;
    strobe.sample  = inBit & (mode == MODE_RX) & (phase == PH_W'(SAMPLE_AT));
    strobe.shift   = bitEnd & (mode == MODE_TX);
    strobe.lowWin  = txWin & (phase < PH_W'(ZERO_END));
    strobe.highWin = txWin & (phase == PH_W'(SPEEDUP_AT));
    strobe.isWord  = isWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= MODE_IDLE;
      inBit   <= 1'b0;
      phase   <= '0;
      bitCnt  <= '0;
      isWord  <= 1'b0;
      idleCnt <= '0;
      rxValid <= 1'b0;
      timeout <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      timeout <= 1'b0;
      if (txFire) begin
        mode    <= MODE_TX;
        isWord  <= txIsWord;
        bitCnt  <= '0;
        idleCnt <= '0;
      end else if (edgeAcc) begin
        inBit   <= 1'b1;
        phase   <= PH_W'(1);
        idleCnt <= '0;
        if (mode == MODE_IDLE) begin
          mode   <= MODE_RX;
          isWord <= rxIsWord;
          bitCnt <= '0;
        end
      end else if (quietLimit) begin
        mode    <= MODE_IDLE;
        timeout <= 1'b1;
        bitCnt  <= '0;
      end else if (mode != MODE_IDLE) begin
        idleCnt <= idleCnt + TO_W'(1);
      end

      if (inBit) begin
        phase <= phase + PH_W'(1);
        if (bitEnd) begin
          inBit  <= 1'b0;
          phase  <= '0;
          bitCnt <= bitCnt + CNT_W'(1);
          if (lastBit) begin
            mode <= MODE_IDLE;
            if (mode == MODE_RX) rxValid <= 1'b1;
          end
        end
      end
    end
  end

  // R2: a window only opens after a detected falling edge
  a_r2_start_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inBit) |-> $past(fall));

  // R4: completion strobe lasts one cycle and leaves the engine idle
  a_r4_rx_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (mode == MODE_IDLE) ##1 !rxValid);

  // R9: timeout is a single-cycle pulse that leaves the engine idle
  a_r9_timeout_pulse: assert property (@(posedge clk) disable iff (!rstN)
    timeout |-> (mode == MODE_IDLE) && !inBit ##1 !timeout);

  // R5: an accepted transfer enters transmit with no bit sent yet
  a_r5_accept_loads: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> (mode == MODE_TX) && (bitCnt == '0) && !inBit);

endmodule

// File: rtl/dbgpin_bit_engine.sv
module dbgpin_bit_engine
  import dbgpin_pkg::*;
#(
  parameter int WORD_BITS      = 16,
  parameter int SHORT_BITS     = 8,
  parameter int SYNC_STAGES    = 2,
  parameter int BIT_CYCLES     = 16,
  parameter int SAMPLE_AT      = 10,
  parameter int ZERO_END       = 13,
  parameter int SPEEDUP_AT     = 4,
  parameter int TIMEOUT_CYCLES = 512
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pinIn,
  output logic                 pinDriveEn,
  output logic                 pinDriveVal,
  input  logic                 txValid,
  output logic                 txReady,
  input  logic [WORD_BITS-1:0] txData,
  input  logic                 txIsWord,
  input  logic                 rxIsWord,
  output logic                 rxValid,
  output logic [WORD_BITS-1:0] rxData,
  output logic                 timeout
);

  dpStrobe_t strobe;
  logic      fall;

  dbgpin_ctrl #(
    .WORD_BITS     (WORD_BITS),
    .SHORT_BITS    (SHORT_BITS),
    .BIT_CYCLES    (BIT_CYCLES),
    .SAMPLE_AT     (SAMPLE_AT),
    .ZERO_END      (ZERO_END),
    .SPEEDUP_AT    (SPEEDUP_AT),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .fall    (fall),
    .txValid (txValid),
    .txIsWord(txIsWord),
    .rxIsWord(rxIsWord),
    .txReady (txReady),
    .rxValid (rxValid),
    .timeout (timeout),
    .strobe  (strobe)
  );

  dbgpin_datapath #(
    .WORD_BITS  (WORD_BITS),
    .SHORT_BITS (SHORT_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .pinIn      (pinIn),
    .txData     (txData),
    .txIsWord   (txIsWord),
    .strobe     (strobe),
    .fall       (fall),
    .rxData     (rxData),
    .pinDriveEn (pinDriveEn),
    .pinDriveVal(pinDriveVal)
  );

  // R8: a high level is only ever driven with the driver enabled
  a_r8_val_with_en: assert property (@(posedge clk) disable iff (!rstN)
    pinDriveVal |-> pinDriveEn);

endmodule

// File: tb/dbgpin_bit_engine_tb_top.sv
module dbgpin_bit_engine_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostLow = 1'b0;
  logic        pinLine;
  logic        pinDriveEn, pinDriveVal;
  logic        txValid = 1'b0;
  logic        txReady;
  logic [15:0] txData = 16'h0;
  logic        txIsWord = 1'b0;
  logic        rxIsWord = 1'b0;
  logic        rxValid;
  logic [15:0] rxData;
  logic        timeout;

  int checks = 0;
  int errors = 0;
  int timeoutSeen = 0;
  int cycles = 0;
  logic [15:0] rxExpect[$];

  always #2 clk = ~clk;

  // open-drain line: low wins, otherwise pulled or driven high
  assign pinLine = (hostLow || (pinDriveEn && !pinDriveVal)) ? 1'b0 : 1'b1;

  dbgpin_bit_engine dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinLine),
    .pinDriveEn(pinDriveEn), .pinDriveVal(pinDriveVal),
    .txValid(txValid), .txReady(txReady), .txData(txData), .txIsWord(txIsWord),
    .rxIsWord(rxIsWord), .rxValid(rxValid), .rxData(rxData), .timeout(timeout)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mS1 = 1, mS2 = 1, mS3 = 1;
  int mMode = 0;               // 0 idle, 1 receive, 2 transmit
  int mIn = 0, mPh = 0, mCnt = 0, mWord = 0, mIdle = 0;
  int mTo = 0, mRxV = 0;
  logic [15:0] mSh = 16'h0;

  function automatic int mFall();
    return (mS3 == 1 && mS2 == 0) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = 1; mS2 = 1; mS3 = 1; mMode = 0; mIn = 0; mPh = 0; mCnt = 0;
      mWord = 0; mIdle = 0; mTo = 0; mRxV = 0; mSh = 16'h0;
    end else begin
      int f, acc, fire, nMode, nIn, nPh, nCnt, nWord, nIdle, nTo, nRxV;
      logic [15:0] nSh;
      f = mFall();
      acc = f && !mIn;
      fire = (mMode == 0 && !mIn && !f && txValid) ? 1 : 0;
      nMode = mMode; nIn = mIn; nPh = mPh; nCnt = mCnt; nWord = mWord;
      nIdle = mIdle; nTo = 0; nRxV = 0; nSh = mSh;
      if (fire) begin
        nMode = 2; nWord = txIsWord; nCnt = 0; nIdle = 0;
        nSh = txIsWord ? txData : {txData[7:0], 8'h00};
      end else if (acc) begin
        nIn = 1; nPh = 1; nIdle = 0;
        if (mMode == 0) begin nMode = 1; nWord = rxIsWord; nCnt = 0; nSh = 16'h0; end
      end else if (mMode != 0) begin
        if (mIdle == 511) begin nMode = 0; nTo = 1; nCnt = 0; nSh = 16'h0; end
        else nIdle = mIdle + 1;
      end
      if (mIn) begin
        nPh = mPh + 1;
        if (mMode == 1 && mPh == 10) nSh = {mSh[14:0], mS2[0]};
        if (mPh == 15) begin
          nIn = 0; nPh = 0; nCnt = mCnt + 1;
          if (mMode == 2) nSh = {mSh[14:0], 1'b0};
          if (mCnt + 1 == (mWord ? 16 : 8)) begin
            nMode = 0;
            if (mMode == 1) nRxV = 1;
          end
        end
      end
      mS3 = mS2; mS2 = mS1; mS1 = pinLine;
      mMode = nMode; mIn = nIn; mPh = nPh; mCnt = nCnt; mWord = nWord;
      mIdle = nIdle; mTo = nTo; mRxV = nRxV; mSh = nSh;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!rstN) begin
      check("R1", "reset drive en", pinDriveEn, 0);
      check("R1", "reset drive val", pinDriveVal, 0);
      check("R1", "reset rxValid", rxValid, 0);
      check("R1", "reset timeout", timeout, 0);
      check("R1", "reset txReady", txReady, 1);
    end else begin
      int bit1, expEn, expVal;
      bit1 = mSh[15];
      expEn = (mMode == 2 && mIn && ((!bit1 && mPh < 13) || (bit1 && mPh == 4))) ? 1 : 0;
      expVal = (expEn && bit1) ? 1 : 0;
      check("R8", "pinDriveEn", pinDriveEn, expEn);
      check(bit1 ? "R7" : "R6", "pinDriveVal", pinDriveVal, expVal);
      check("R5", "txReady", txReady, (mMode == 0 && !mIn && !mFall()) ? 1 : 0);
      check("R4", "rxValid", rxValid, mRxV);
      check("R9", "timeout", timeout, mTo);
      if (rxValid) begin
        check("R3", "rxData model", rxData, mWord ? mSh : {8'h00, mSh[7:0]});
        if (rxExpect.size() == 0) check("R4", "unexpected rxValid", 1, 0);
        else check("R3", "rxData frame", rxData, rxExpect.pop_front());
      end
      if (timeout) timeoutSeen++;
    end
  end

  // ---------------- host side ----------------
  task automatic hostRxBit(input logic b);
    @(negedge clk); hostLow = 1'b1;
    repeat (b ? 3 : 13) @(negedge clk);
    hostLow = 1'b0;
    repeat (b ? 20 : 10) @(negedge clk);
  endtask

  // extra edge inside the window must be ignored (R2)
  task automatic hostRxGlitchOne();
    @(negedge clk); hostLow = 1'b1;
    repeat (3) @(negedge clk); hostLow = 1'b0;
    repeat (3) @(negedge clk); hostLow = 1'b1;
    repeat (2) @(negedge clk); hostLow = 1'b0;
    repeat (15) @(negedge clk);
  endtask

  task automatic hostRxFrame(input logic [15:0] v, input int n);
    rxIsWord = (n == 16);
    rxExpect.push_back(n == 16 ? v : {8'h00, v[7:0]});
    for (int i = n - 1; i >= 0; i--) hostRxBit(v[i]);
    repeat (4) @(negedge clk);
  endtask

  task automatic hostTxBit(output logic b);
    @(negedge clk); hostLow = 1'b1;
    repeat (3) @(negedge clk); hostLow = 1'b0;
    repeat (8) @(negedge clk);
    b = pinLine;
    repeat (12) @(negedge clk);
  endtask

  task automatic offerTx(input logic [15:0] d, input logic w);
    txData = d; txIsWord = w; txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0; txData = 16'hDEAD;
  endtask

  task automatic hostTxFrame(input int n, input logic [15:0] exp, input string req);
    logic [15:0] got;
    logic b;
    got = 16'h0;
    for (int i = 0; i < n; i++) begin
      hostTxBit(b);
      got = {got[14:0], b};
    end
    check(req, "host decoded tx", got, exp);
    repeat (4) @(negedge clk);
    check("R10", "txReady after tx", txReady, 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  // ---------------- sequence ----------------
  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R3 R4: receives of both lengths and extreme values
    hostRxFrame(16'h00A5, 8);
    hostRxFrame(16'h3C96, 16);
    hostRxFrame(16'h0000, 8);
    hostRxFrame(16'hFFFF, 16);

    // R2: glitch edge in the first window of a byte (bit value 1)
    rxIsWord = 1'b0;
    rxExpect.push_back(16'h0081);
    hostRxGlitchOne();
    for (int i = 6; i >= 0; i--) hostRxBit(i == 0);
    repeat (4) @(negedge clk);

    // R5 R6 R7: byte transmit ignores upper half; word transmit
    offerTx(16'hFF5A, 1'b0);
    hostTxFrame(8, 16'h005A, "R5");
    offerTx(16'hC3A1, 1'b1);
    hostTxFrame(16, 16'hC3A1, "R6");
    offerTx(16'h00FF, 1'b0);
    hostTxFrame(8, 16'h00FF, "R7");

    // R9: receive abandoned mid-frame, then a fresh byte is accepted
    rxIsWord = 1'b0;
    hostRxBit(1'b1); hostRxBit(1'b0); hostRxBit(1'b1);
    repeat (600) @(negedge clk);
    check("R9", "timeout count after rx stall", timeoutSeen, 1);
    hostRxFrame(16'h0042, 8);

    // R9: accepted transmit with no host edges
    offerTx(16'h1234, 1'b1);
    repeat (600) @(negedge clk);
    check("R9", "timeout count after tx stall", timeoutSeen, 2);
    check("R9", "txReady after tx timeout", txReady, 1);
    offerTx(16'h0096, 1'b0);
    hostTxFrame(8, 16'h0096, "R9");

    repeat (10) @(negedge clk);
    check("R4", "rx frames left", rxExpect.size(), 0);
    check("R9", "timeouts total", timeoutSeen, 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule